// File: doc/BRIEF.md
# Video RAM Contention Wait-State Generator

This block shares one video RAM between a video fetch engine and a Z80-style CPU. It runs on the CPU T-state clock. While the beam is inside the display area, a phase counter splits time into repeating eight-T-state groups. The video fetch owns the RAM for the first six phases of each group, and the CPU is free to use it in the last two. A CPU cycle that targets the shared region during a fetch-owned phase is stalled through an active-low wait output. The stall lasts until the next free phase begins.

Memory cycles are recognised from the memory-request strobe alone. The decision to stall is taken only on the T-state that opens an M-cycle. Cycles that carry an I/O request with a shared-region address are stalled in the same way. If the memory strobe is low later in an M-cycle, as happens in the refresh half of an opcode fetch, and the address falls in the shared region during a fetch-owned phase, the CPU is not stalled. Instead the block raises a flag that marks the current video fetch as corrupted, because the fetch would pick up the address on the CPU bus. The block also provides a port-select output, decoded from the I/O strobe and address bit 0 only.

Top module: `vram_contention`

## Requirements
- R1: A synchronous active-high reset drives wait_n high, drives fetch_corrupt low and returns the phase counter to phase 0. The rising edge that follows the release of reset, with disp_active high, samples phase 0.
- R2: While disp_active is high, the phase advances by one on every clock edge and wraps from 7 to 0. Phases 0 to 5 are owned by the video fetch and phases 6 and 7 are free. A stall can therefore last at most 5 T-states.
- R3: If at a clock edge mcycle_first=1, mreq_n=0, addr_top=2'b01 (A15=0, A14=1) and the sampled phase p is between 0 and 4, then wait_n is low from the next cycle for exactly 5-p cycles. It goes high again when phase 6 is reached.
- R4: An access whose addr_top is not 2'b01 never drives wait_n low.
- R5: wait_n only falls after an edge at which mcycle_first was 1. Activity on mreq_n while mcycle_first=0 never starts a stall.
- R6: An I/O cycle (iorq_n=0) that opens an M-cycle with addr_top=2'b01 stalls in the same way as the memory cycle in R3.
- R7: port_sel is high, with no register in the path, exactly when iorq_n=0 and addr_lsb=0. No other address bit affects it.
- R8: If at a clock edge disp_active=1, the phase is 0 to 5, mreq_n=0, mcycle_first=0, addr_top=2'b01 and no stall is in progress, then fetch_corrupt is high in the next cycle. This condition never causes a stall, and fetch_corrupt and a low wait_n never occur together.
- R9: When disp_active is low at an edge, the next cycle has wait_n high and fetch_corrupt low, and the phase counter is back at 0. Any stall in progress ends at once.
- R10: A qualifying access sampled in phase 5, 6 or 7 causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_top | input | 2 | CPU address bits A15:A14 |
| addr_lsb | input | 1 | CPU address bit A0 |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| mcycle_first | input | 1 | High on the first T-state of an M-cycle |
| disp_active | input | 1 | Beam is inside the display area |
| wait_n | output | 1 | Wait request to the CPU, active low |
| fetch_corrupt | output | 1 | Current video fetch would use the CPU bus address |
| port_sel | output | 1 | Block's I/O port selected |

## Verification
A phase counter that drifts from the reference shows up within one group of eight T-states. Stalls then have the wrong length, or stalls appear at phases 5 to 7. A stall flag that is not cleared leaves wait_n low past phase 6 or while the display is off, which is visible on the very next cycle. A corruption term with a missing qualifier raises fetch_corrupt on first T-states or outside the shared region, which is visible one cycle after the stimulus. For these reasons the bench compares both registered outputs against an independent model on every cycle, and it uses directed runs that start a hit at each of the eight phases.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

    parameter int PHASE_W     = 3;
    parameter int BUSY_PHASES = 6;

    localparam int NUM_PHASES = 1 << PHASE_W;

    typedef logic [PHASE_W-1:0] phase_t;

    // Snapshot of the CPU bus for one T-state
    typedef struct packed {
        logic first;   // opening T-state of an M-cycle
        logic mem;     // memory strobe active
        logic io;      // I/O strobe active
        logic region;  // address inside the shared window
    } cpu_req_t;

    // Shared window: A15 = 0, A14 = 1
    function automatic logic in_shared_window(input logic [1:0] top);
        return top == 2'b01;
    endfunction

endpackage

// File: rtl/vram_slot_timer.sv
module vram_slot_timer
    import vram_arb_pkg::*;
#(
    parameter int PW   = PHASE_W,
    parameter int BUSY = BUSY_PHASES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          disp_active,
    output logic [PW-1:0] phase,
    output logic          busy,
    output logic          busy_last
);

    localparam logic [PW-1:0] LAST_BUSY = PW'(BUSY - 1);
    localparam logic [PW-1:0] BUSY_LIM  = PW'(BUSY);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || !disp_active) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign phase     = phase_q;
    assign busy      = disp_active && (phase_q < BUSY_LIM);
    assign busy_last = busy && (phase_q == LAST_BUSY);

endmodule

// File: rtl/vram_stall_ctl.sv
module vram_stall_ctl
    import vram_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     disp_active,
    input  logic     busy,
    input  logic     busy_last,
    input  cpu_req_t req,
    output logic     stall
);

    logic stall_q;
    logic start_hit;
    logic keep_going;

    // A stall is only ever opened on the first T-state of an M-cycle
    assign start_hit  = req.first && req.region && (req.mem || req.io);
    // The stall must end when the next phase is free
    assign keep_going = busy && !busy_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q <= 1'b0;
        end else begin
            stall_q <= disp_active && keep_going && (stall_q || start_hit);
        end
    end

    assign stall = stall_q;

endmodule

// File: rtl/vram_snoop_detect.sv
module vram_snoop_detect
    import vram_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     disp_active,
    input  logic     busy,
    input  logic     stall,
    input  cpu_req_t req,
    output logic     corrupt
);

    logic corrupt_q;
    logic late_mem;

    // Memory strobe seen after the opening T-state (e.g. refresh half of M1)
    assign late_mem = req.mem && !req.first && req.region;

    always_ff @(posedge clk) begin
        if (rst) begin
            corrupt_q <= 1'b0;
        end else begin
            corrupt_q <= disp_active && busy && late_mem && !stall;
        end
    end

    assign corrupt = corrupt_q;

endmodule

// File: rtl/vram_contention.sv
module vram_contention
    import vram_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] addr_top,
    input  logic       addr_lsb,
    input  logic       mreq_n,
    input  logic       iorq_n,
    input  logic       mcycle_first,
    input  logic       disp_active,
    output logic       wait_n,
    output logic       fetch_corrupt,
    output logic       port_sel
);

    cpu_req_t req;
    phase_t   phase;
    logic     busy;
    logic     busy_last;
    logic     stall;
    logic     corrupt;

    always_comb begin
        req.first  = mcycle_first;
        req.mem    = !mreq_n;
        req.io     = !iorq_n;
        req.region = in_shared_window(addr_top);
    end

    vram_slot_timer #(
        .PW   (PHASE_W),
        .BUSY (BUSY_PHASES)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .disp_active (disp_active),
        .phase       (phase),
        .busy        (busy),
        .busy_last   (busy_last)
    );

    vram_stall_ctl u_stall (
        .clk         (clk),
        .rst         (rst),
        .disp_active (disp_active),
        .busy        (busy),
        .busy_last   (busy_last),
        .req         (req),
        .stall       (stall)
    );

    vram_snoop_detect u_snoop (
        .clk         (clk),
        .rst         (rst),
        .disp_active (disp_active),
        .busy        (busy),
        .stall       (stall),
        .req         (req),
        .corrupt     (corrupt)
    );

    assign wait_n        = !stall;
    assign fetch_corrupt = corrupt;
    // Partial decode: only the I/O strobe and A0 matter
    assign port_sel      = !iorq_n && !addr_lsb;

endmodule

// File: rtl/vram_contention_chk.sv
module vram_contention_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] addr_top,
    input logic       mcycle_first,
    input logic       disp_active,
    input logic       wait_n,
    input logic       fetch_corrupt
);

    logic [3:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || wait_n) begin
            low_run <= '0;
        end else if (low_run != 4'hF) begin
            low_run <= low_run + 1'b1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wait_n && !fetch_corrupt)); // R1

    AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        !wait_n |-> (low_run < 4'd5)); // R2

    AST_STALL_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $fell(wait_n) |-> $past(addr_top == 2'b01)); // R4

    AST_STALL_ON_FIRST: assert property (@(posedge clk) disable iff (rst)
        $fell(wait_n) |-> $past(mcycle_first)); // R5

    AST_CORRUPT_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        fetch_corrupt |-> wait_n); // R8

    AST_WAIT_NEEDS_DISP: assert property (@(posedge clk) disable iff (rst)
        !wait_n |-> $past(disp_active)); // R9

    AST_CORRUPT_NEEDS_DISP: assert property (@(posedge clk) disable iff (rst)
        fetch_corrupt |-> $past(disp_active)); // R9

endmodule

bind vram_contention vram_contention_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .addr_top      (addr_top),
    .mcycle_first  (mcycle_first),
    .disp_active   (disp_active),
    .wait_n        (wait_n),
    .fetch_corrupt (fetch_corrupt)
);

// File: tb/vram_contention_tb.sv
module vram_contention_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] addr_top;
    logic       addr_lsb;
    logic       mreq_n;
    logic       iorq_n;
    logic       mcycle_first;
    logic       disp_active;
    logic       wait_n;
    logic       fetch_corrupt;
    logic       port_sel;

    int checks = 0;
    int fails  = 0;
    logic cmp_en = 1'b0;
    logic done   = 1'b0;

    always #10 clk = ~clk;

    vram_contention u_dut (
        .clk           (clk),
        .rst           (rst),
        .addr_top      (addr_top),
        .addr_lsb      (addr_lsb),
        .mreq_n        (mreq_n),
        .iorq_n        (iorq_n),
        .mcycle_first  (mcycle_first),
        .disp_active   (disp_active),
        .wait_n        (wait_n),
        .fetch_corrupt (fetch_corrupt),
        .port_sel      (port_sel)
    );

    // Reference model written from the requirements
    logic [2:0] m_phase;
    logic       m_stall;
    logic       m_corrupt;

    function automatic logic exp_stall(input logic st, input logic [2:0] ph,
                                       input logic first, input logic mem,
                                       input logic io, input logic win);
        logic start;
        start = first && win && (mem || io);
        return (st || start) && (ph < 3'd5);
    endfunction

    function automatic logic exp_corrupt(input logic st, input logic [2:0] ph,
                                         input logic first, input logic mem,
                                         input logic win);
        return (ph < 3'd6) && mem && !first && win && !st;
    endfunction

    always @(posedge clk) begin
        if (rst || !disp_active) begin
            m_phase   <= 3'd0;
            m_stall   <= 1'b0;
            m_corrupt <= 1'b0;
        end else begin
            m_phase   <= m_phase + 3'd1;
            m_stall   <= exp_stall(m_stall, m_phase, mcycle_first, !mreq_n,
                                   !iorq_n, addr_top == 2'b01);
            m_corrupt <= exp_corrupt(m_stall, m_phase, mcycle_first, !mreq_n,
                                     addr_top == 2'b01);
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            check("R3 wait_n vs model", wait_n, !m_stall);
            check("R8 fetch_corrupt vs model", fetch_corrupt, m_corrupt);
            check("R7 port_sel", port_sel, !iorq_n && !addr_lsb);
        end
    end

    task automatic drive(input logic d, input logic f, input logic m,
                         input logic io, input logic [1:0] t, input logic l);
        @(negedge clk);
        #1;
        disp_active  = d;
        mcycle_first = f;
        mreq_n       = m;
        iorq_n       = io;
        addr_top     = t;
        addr_lsb     = l;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
    endtask

    // Start an access at phase p and count stalled cycles over the next 8
    task automatic hit_at(input int p, input logic io_cyc, input logic [1:0] t,
                          input logic first, input int exp, input string tag);
        int low;
        drive(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
        idle(p);
        drive(1'b1, first, io_cyc, !io_cyc, t, 1'b1);
        low = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!wait_n) low++;
            #1;
            disp_active = 1'b1; mcycle_first = 1'b0; mreq_n = 1'b1;
            iorq_n = 1'b1; addr_top = 2'b00;
        end
        check_int(tag, low, exp);
    endtask

    task automatic snow_at(input int p, input logic [1:0] t, input logic exp,
                           input string tag);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
        idle(p);
        drive(1'b1, 1'b0, 1'b0, 1'b1, t, 1'b1);
        @(negedge clk);
        check(tag, fetch_corrupt, exp);
        check({tag, " no stall"}, wait_n, 1'b1);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; disp_active = 1'b1; mcycle_first = 1'b1; mreq_n = 1'b0;
        iorq_n = 1'b1; addr_top = 2'b01; addr_lsb = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 wait_n in reset", wait_n, 1'b1);
        check("R1 fetch_corrupt in reset", fetch_corrupt, 1'b0);
        // Release reset with a hit waiting: first edge is phase 0 -> 5 stall cycles
        #1 rst = 1'b0;
        begin
            int low = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (!wait_n) low++;
                #1 mcycle_first = 1'b0; mreq_n = 1'b1;
            end
            check_int("R1 phase 0 after reset", low, 5);
        end
        cmp_en = 1'b1;

        // Stall length per starting phase
        for (int p = 0; p < 8; p++) begin
            hit_at(p, 1'b0, 2'b01, 1'b1, (p < 5) ? 5 - p : 0,
                   (p < 5) ? "R2 R3 stall length" : "R10 late phase no stall");
        end
        hit_at(0, 1'b1, 2'b01, 1'b1, 5, "R6 io stall phase 0");
        hit_at(3, 1'b1, 2'b01, 1'b1, 2, "R6 io stall phase 3");
        hit_at(0, 1'b0, 2'b00, 1'b1, 0, "R4 low region");
        hit_at(0, 1'b0, 2'b11, 1'b1, 0, "R4 high region");
        hit_at(1, 1'b1, 2'b10, 1'b1, 0, "R4 io outside window");
        hit_at(0, 1'b0, 2'b01, 1'b0, 0, "R5 late strobe no stall");

        // Corrupted fetch
        snow_at(0, 2'b01, 1'b1, "R8 corrupt phase 0");
        snow_at(5, 2'b01, 1'b1, "R8 corrupt phase 5");
        snow_at(6, 2'b01, 1'b0, "R8 free phase no corrupt");
        snow_at(2, 2'b00, 1'b0, "R8 outside window no corrupt");

        // Display off
        drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1);
        @(negedge clk);
        check("R9 no stall when display off", wait_n, 1'b1);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1);
        @(negedge clk);
        check("R9 no corrupt when display off", fetch_corrupt, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
        check("R9 stall started", wait_n, 1'b0);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
        @(negedge clk);
        check("R9 stall ends when display drops", wait_n, 1'b1);

        // Port decode
        drive(1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0);
        @(negedge clk);
        check("R7 port selected", port_sel, 1'b1);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1);
        @(negedge clk);
        check("R7 odd port not selected", port_sel, 1'b0);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0);
        @(negedge clk);
        check("R7 no io strobe", port_sel, 1'b0);

        // Constrained random traffic, compared by the model every cycle
        for (int i = 0; i < 6000; i++) begin
            logic [3:0] r;
            r = 4'($urandom_range(0, 15));
            drive(r != 0, 1'($urandom_range(0, 3) == 0), 1'($urandom),
                  1'($urandom_range(0, 3) != 0),
                  ($urandom_range(0, 1) == 0) ? 2'b01 : 2'($urandom),
                  1'($urandom));
        end
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule